// File: doc/BRIEF.md
# Iterative Integer Multiply-Divide Unit with Private Result Pair

This block performs 32-bit integer multiplication and division for a processor core. Each operation writes into its own pair of result registers, called HI and LO. A request names one of four operations: signed multiply, unsigned multiply, signed divide or unsigned divide. It also carries two operands. An accepted request runs for a fixed 32 cycles and handles one bit per clock. A multiply leaves the 64-bit product split across the pair. A divide leaves the quotient in LO and the remainder in HI. No operation ever raises an arithmetic fault.

The issuing pipeline reads the result with a move-from request that selects HI or LO. While an operation is still running, the unit holds the read off (its ready output stays low) until the result pair has been written. A request to start an operation while the unit is busy is refused, and the accept strobe shows whether a start was taken.

Top module: `muldiv_hilo`

## Requirements
- R1: Operation code 2'b00 (bit 1 = divide, bit 0 = unsigned) is a signed multiply. It leaves the upper 32 bits of the full two's-complement 64-bit product in HI and the lower 32 bits in LO.
- R2: Operation code 2'b01 is an unsigned multiply. It leaves the upper half of the 64-bit unsigned product in HI and the lower half in LO.
- R3: Operation code 2'b10 is a signed divide. It writes to LO the quotient truncated toward zero, and to HI the remainder, which carries the sign of the dividend.
- R4: Operation code 2'b11 is an unsigned divide. It writes the quotient to LO and the remainder to HI.
- R5: `busy` rises on the clock edge that accepts an operation and stays high for exactly 32 cycles. HI and LO take the new result on the edge where `busy` falls.
- R6: `op_accept` equals `op_valid` while `busy` is low and stays low while `busy` is high. A start request made while busy changes neither the running operation nor its result.
- R7: `rd_ready` equals `rd_valid` while `busy` is low and stays low while `busy` is high. `rd_data` shows HI when `rd_sel` is 1 and LO when it is 0. A read never changes either register.
- R8: A divide by zero completes in the same 32 cycles without any fault. Afterwards the unit accepts new work normally. The HI and LO values it leaves are not specified.
- R9: After reset, `busy` is low and HI and LO are both zero.
- R10: A signed divide of the most negative value by -1 gives quotient 0x80000000 and remainder 0, with no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request to start an operation |
| op_code | input | 2 | Bit 1: divide; bit 0: unsigned |
| op_a | input | 32 | Multiplicand or dividend |
| op_b | input | 32 | Multiplier or divisor |
| op_accept | output | 1 | The start request is taken this cycle |
| busy | output | 1 | An operation is in progress |
| rd_valid | input | 1 | Move-from request |
| rd_sel | input | 1 | 1 selects HI, 0 selects LO |
| rd_ready | output | 1 | Move-from request is served this cycle |
| rd_data | output | 32 | Copy of the selected register |

## Verification
The hardest situations to reach from the ports are the ones that overlap a running operation. These are a second start request, and a move-from read arriving while the loop is partway through its 32 steps. The read must stall and then be served with the new value, and the second start must leave no trace. The stimulus makes both happen during every operation. It pulses a second start request a few cycles into the run and keeps move-from reads asserted, toggling the select, through the whole run and past its end. It also issues starts on the very cycle `busy` falls. Operand corners (most negative value, -1, zero divisor, all ones) are mixed with random operands across all four operation codes.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    // bit 1 selects divide, bit 0 selects unsigned
    typedef enum logic [1:0] {
        MD_MUL_S = 2'b00,
        MD_MUL_U = 2'b01,
        MD_DIV_S = 2'b10,
        MD_DIV_U = 2'b11
    } md_op_e;

endpackage

// File: rtl/md_operand_prep.sv
module md_operand_prep #(
    parameter int W = 32
) (
    input  muldiv_pkg::md_op_e op,
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    output logic [W-1:0]       mag_a,
    output logic [W-1:0]       mag_b,
    output logic               neg_main,
    output logic               neg_rem
);
    logic is_signed;

    always_comb begin
        is_signed = (op == muldiv_pkg::MD_MUL_S) || (op == muldiv_pkg::MD_DIV_S);
        mag_a     = (is_signed && a[W-1]) ? (~a + 1'b1) : a;
        mag_b     = (is_signed && b[W-1]) ? (~b + 1'b1) : b;
        neg_main  = is_signed && (a[W-1] ^ b[W-1]);
        neg_rem   = is_signed && a[W-1];
    end
endmodule

// File: rtl/md_mul_step.sv
module md_mul_step #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] work,
    input  logic [W-1:0]   mcand,
    output logic [2*W-1:0] work_next
);
    logic [W:0] upper_sum;

    always_comb begin
        upper_sum = {1'b0, work[2*W-1:W]} + (work[0] ? {1'b0, mcand} : '0);
        work_next = {upper_sum, work[W-1:1]};
    end
endmodule

// File: rtl/md_div_step.sv
module md_div_step #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] work,
    input  logic [W-1:0]   divisor,
    output logic [2*W-1:0] work_next
);
    logic [W:0]   shifted;
    logic [W+1:0] diff;
    logic         borrow;

    always_comb begin
        shifted   = {work[2*W-1:W], work[W-1]};
        diff      = {1'b0, shifted} - {2'b00, divisor};
        borrow    = diff[W+1];
        work_next = {(borrow ? shifted[W-1:0] : diff[W-1:0]), work[W-2:0], ~borrow};
    end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [1:0]   op_code,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         op_accept,
    output logic         busy,
    input  logic         rd_valid,
    input  logic         rd_sel,
    output logic         rd_ready,
    output logic [W-1:0] rd_data
);
    import muldiv_pkg::*;

    localparam int            CW   = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic           busy;
        logic [CW-1:0]  cnt;
        logic           is_div;
        logic           neg_main;
        logic           neg_rem;
        logic [W-1:0]   oper;
        logic [2*W-1:0] work;
        logic [W-1:0]   hi;
        logic [W-1:0]   lo;
    } md_state_t;

    md_state_t st_d, st_q;

    md_op_e         op_e;
    logic [W-1:0]   mag_a, mag_b;
    logic           neg_main, neg_rem;
    logic [2*W-1:0] mul_next, div_next, step_next;
    logic [2*W-1:0] prod_fix;
    logic [W-1:0]   quo_fix, rem_fix;

    assign op_e = md_op_e'(op_code);

    md_operand_prep #(.W(W)) u_prep (
        .op       (op_e),
        .a        (op_a),
        .b        (op_b),
        .mag_a    (mag_a),
        .mag_b    (mag_b),
        .neg_main (neg_main),
        .neg_rem  (neg_rem)
    );

    md_mul_step #(.W(W)) u_mul (
        .work      (st_q.work),
        .mcand     (st_q.oper),
        .work_next (mul_next)
    );

    md_div_step #(.W(W)) u_div (
        .work      (st_q.work),
        .divisor   (st_q.oper),
        .work_next (div_next)
    );

    always_comb begin
        step_next = st_q.is_div ? div_next : mul_next;
        prod_fix  = st_q.neg_main ? (~step_next + 1'b1) : step_next;
        quo_fix   = st_q.neg_main ? (~step_next[W-1:0] + 1'b1) : step_next[W-1:0];
        rem_fix   = st_q.neg_rem ? (~step_next[2*W-1:W] + 1'b1) : step_next[2*W-1:W];
    end

    always_comb begin
        st_d      = st_q;
        op_accept = op_valid && !st_q.busy;
        if (op_accept) begin
            st_d.busy     = 1'b1;
            st_d.cnt      = '0;
            st_d.is_div   = op_code[1];
            st_d.neg_main = neg_main;
            st_d.neg_rem  = neg_rem;
            st_d.oper     = op_code[1] ? mag_b : mag_a;
            st_d.work     = {{W{1'b0}}, (op_code[1] ? mag_a : mag_b)};
        end else if (st_q.busy) begin
            st_d.work = step_next;
            st_d.cnt  = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                if (st_q.is_div) begin
                    st_d.hi = rem_fix;
                    st_d.lo = quo_fix;
                end else begin
                    st_d.hi = prod_fix[2*W-1:W];
                    st_d.lo = prod_fix[W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign rd_ready = rd_valid && !st_q.busy;
    assign rd_data  = rd_sel ? st_q.hi : st_q.lo;

endmodule

// File: rtl/md_checker.sv
module md_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic         op_accept,
    input logic         busy,
    input logic         rd_valid,
    input logic         rd_sel,
    input logic         rd_ready,
    input logic [W-1:0] rd_data
);
    localparam int RW = $clog2(W) + 1;

    logic [RW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run <= '0;
        else if (busy) run <= run + 1'b1;
        else           run <= '0;
    end

    // R5
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_accept |=> busy);

    // R5
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run == RW'(W)));

    // R5
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run < RW'(W)));

    // R6
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !op_accept);

    // R6
    accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy) |-> op_accept);

    // R7
    read_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> (rd_valid && !busy));

    // R7
    read_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !busy) |-> rd_ready);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && (rd_sel == $past(rd_sel))) |-> $stable(rd_data));
endmodule

bind muldiv_hilo md_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_accept (op_accept),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .rd_sel    (rd_sel),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data)
);

// File: tb/muldiv_hilo_test.sv
module muldiv_hilo_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'b00;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        op_accept, busy;
    logic        rd_valid = 1'b0;
    logic        rd_sel = 1'b0;
    logic        rd_ready;
    logic [31:0] rd_data;

    muldiv_hilo uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_a(op_a), .op_b(op_b), .op_accept(op_accept), .busy(busy),
        .rd_valid(rd_valid), .rd_sel(rd_sel), .rd_ready(rd_ready), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string tag = "R9";

    // reference model state
    bit          m_busy = 1'b0;
    int          m_left = 0;
    logic [31:0] m_hi = '0, m_lo = '0;
    bit          m_unk = 1'b0;
    logic [31:0] p_hi, p_lo;
    bit          p_unk;

    task automatic model_result(input logic [1:0] code, input logic [31:0] a, input logic [31:0] b);
        longint      sa, sb, sp, sq, sr;
        logic [63:0] up;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        p_unk = 1'b0;
        case (code)
            2'b00: begin sp = sa * sb; p_hi = sp[63:32]; p_lo = sp[31:0]; end
            2'b01: begin up = {32'b0, a} * {32'b0, b}; p_hi = up[63:32]; p_lo = up[31:0]; end
            2'b10: begin
                if (b == 0) begin p_unk = 1'b1; p_hi = '0; p_lo = '0; end
                else begin sq = sa / sb; sr = sa % sb; p_lo = sq[31:0]; p_hi = sr[31:0]; end
            end
            default: begin
                if (b == 0) begin p_unk = 1'b1; p_hi = '0; p_lo = '0; end
                else begin p_lo = a / b; p_hi = a % b; end
            end
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_left = 0; m_hi = '0; m_lo = '0; m_unk = 1'b0;
        end else if (m_busy) begin
            m_left = m_left - 1;
            if (m_left == 0) begin
                m_busy = 1'b0; m_hi = p_hi; m_lo = p_lo; m_unk = p_unk;
            end
        end else if (op_valid) begin
            model_result(op_code, op_a, op_b);
            m_busy = 1'b1; m_left = 32;
        end
    end

    task automatic check1(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check1("busy", {31'b0, busy}, {31'b0, m_busy});
            check1("op_accept", {31'b0, op_accept}, {31'b0, op_valid && rst_n && !m_busy});
            check1("rd_ready", {31'b0, rd_ready}, {31'b0, rd_valid && !m_busy});
            if (rd_valid && !m_busy && !m_unk)
                check1(rd_sel ? "rd_data HI" : "rd_data LO", rd_data, rd_sel ? m_hi : m_lo);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // one operation with overlapping start attempt (R6) and stalled reads (R7)
    task automatic run_op(input string t, input logic [1:0] code, input logic [31:0] a, input logic [31:0] b);
        tag = t;
        op_valid = 1'b1; op_code = code; op_a = a; op_b = b;
        tick();
        op_valid = 1'b0;
        for (int i = 0; i < 38; i++) begin
            rd_valid = 1'b1;
            rd_sel = i[0];
            if (i == 4) begin
                op_valid = 1'b1; op_code = ~code; op_a = 32'h1234_5678; op_b = 32'h3;
            end else begin
                op_valid = 1'b0;
            end
            tick();
        end
        op_valid = 1'b0;
        rd_valid = 1'b0;
    endtask

    initial begin
        // R9: reset state
        rd_valid = 1'b1;
        repeat (3) tick();
        rd_sel = 1'b1;
        tick();
        rst_n = 1'b1;
        tick(); tick();
        rd_sel = 1'b0;
        tick();

        run_op("R1", 2'b00, 32'hFFFF_FFFD, 32'h0000_0007);
        run_op("R1", 2'b00, 32'h8000_0000, 32'h8000_0000);
        run_op("R1", 2'b00, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        run_op("R2", 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op("R2", 2'b01, 32'h8000_0000, 32'h0000_0002);
        run_op("R3", 2'b10, 32'hFFFF_FFF9, 32'h0000_0002);
        run_op("R3", 2'b10, 32'h0000_0007, 32'hFFFF_FFFE);
        run_op("R3", 2'b10, 32'hFFFF_FFF9, 32'hFFFF_FFFE);
        run_op("R10", 2'b10, 32'h8000_0000, 32'hFFFF_FFFF);
        run_op("R4", 2'b11, 32'hFFFF_FFFF, 32'h0000_0010);
        run_op("R4", 2'b11, 32'h0000_0005, 32'h0000_0009);
        run_op("R8", 2'b11, 32'h0000_1234, 32'h0000_0000);
        run_op("R8", 2'b10, 32'hFFFF_0000, 32'h0000_0000);
        run_op("R4", 2'b11, 32'h0001_0000, 32'h0000_0003);

        // R5: start again on the cycle busy falls, back to back
        tag = "R5";
        op_valid = 1'b1; op_code = 2'b01; op_a = 32'd1000; op_b = 32'd3000;
        rd_valid = 1'b1;
        for (int i = 0; i < 100; i++) begin
            rd_sel = i[1];
            op_a = op_a + 32'd17;
            tick();
        end
        op_valid = 1'b0;
        repeat (40) tick();
        rd_valid = 1'b0;

        // mixed random operations across all codes
        for (int k = 0; k < 40; k++) begin
            logic [1:0]  c;
            logic [31:0] ra, rb;
            c  = 2'(k);
            ra = $urandom();
            rb = (k % 5 == 0) ? 32'($urandom_range(1, 9)) : $urandom();
            case (c)
                2'b00: run_op("R1", c, ra, rb);
                2'b01: run_op("R2", c, ra, rb);
                2'b10: run_op("R3", c, ra, rb);
                default: run_op("R4", c, ra, rb);
            endcase
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > MAX_CYCLES && !done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, MAX_CYCLES);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule